// File: doc/BRIEF.md
# Multi-PHY Cell Receive Port (PHY side, 8-bit)

This block is the PHY end of a shared, polled receive bus that carries fixed-length 53-byte cells to an ATM-layer master. One port owns one bus address. The master cycles the address lines through the PHYs it serves and places the all-ones null address between polls. When the address matches, the port reports on the next cycle whether it has a complete cell to offer. The data and cell-available lines are shared by all PHYs, so every line this port drives has its own output-enable, which stands in for a tri-state buffer.

To pull a cell, the master puts the port's address on the bus for one cycle and then drops the active-low enable. The port treats itself as selected from that falling edge of enable. Starting on that edge, it takes one byte per clock from its internal cell FIFO and drives it onto the data lines. The first byte of each cell is flagged by start-of-cell. If enable rises partway through a cell, the port keeps its place in the cell and carries on from the same byte when it is selected again. The selection ends by itself after the last byte of a cell.

The FIFO side is a valid/ready stream. `fifo_ready` is high only while the port is selected and enable is low. A byte moves on a clock edge where both `fifo_valid` and `fifo_ready` are high. If `fifo_valid` is low, the output byte holds, the position in the cell does not advance, and start-of-cell stays low. A byte tagged with `fifo_sop` always counts as byte 0 of a new cell.

Top module: `utopia_rx_port`

## Requirements
- R1: Each byte taken from the FIFO appears on `rx_data` after the clock edge that takes it, with the bit order unchanged (bit 7 is the most significant bit).
- R2: `rx_soc` is 1 only for the byte at position 0 of a cell, and it is never 1 while `rx_data_oe` is 0.
- R3: One byte is taken per edge only while the port is selected and `rx_enb_n` is 0. When `fifo_valid` is 0, `rx_data` holds its value and no byte is consumed.
- R4: `rx_data_oe` is 1 after an edge at which the port was selected with `rx_enb_n` at 0. It is 0 after any edge at which `rx_enb_n` was 1.
- R5: After an edge at which `rx_addr` equals the port address, `rx_clav_oe` is 1 and `rx_clav` shows whether `cell_ready` was 1.
- R6: After an edge at which `rx_addr` is the null address 5'h1F, or any other address, `rx_clav_oe` is 0.
- R7: While a cell is part-way through transfer (position not 0), a poll of the port's address returns `rx_clav` = 1 even if `cell_ready` is 0.
- R8: The port is selected only when its address is on `rx_addr` in the cycle just before `rx_enb_n` falls. A different address there, or the port's address while enable is already low, starts no transfer.
- R9: After byte 52 (the 53rd byte) the selection ends. No further byte is taken until enable rises and the port is selected again.
- R10: If `rx_enb_n` rises in mid-cell, the position is kept. The next selection resumes with the following byte, and `rx_soc` stays 0.
- R11: A byte tagged with `fifo_sop` is output with `rx_soc` = 1 and restarts the count, so the cell then ends 53 bytes after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive byte clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_addr | input | 5 | Bus address from the master; 5'h1F is the null address |
| rx_enb_n | input | 1 | Active-low enable from the master |
| cell_ready | input | 1 | The FIFO holds at least one complete cell |
| fifo_valid | input | 1 | The FIFO byte on `fifo_data` is valid |
| fifo_data | input | 8 | FIFO byte |
| fifo_sop | input | 1 | The FIFO byte is the first byte of a cell |
| fifo_ready | output | 1 | The port takes the FIFO byte at this edge |
| rx_clav | output | 1 | Cell-available answer to a poll |
| rx_clav_oe | output | 1 | Drive enable for `rx_clav` |
| rx_data | output | 8 | Cell byte toward the master |
| rx_soc | output | 1 | Start-of-cell marker for `rx_data` |
| rx_data_oe | output | 1 | Drive enable for `rx_data` and `rx_soc` |

## Verification
The bench builds the port with address 5'd30, which sits right next to the null code 5'h1F, so a decode that mixes up its own address and the null address shows up. Data width and cell length keep their defaults of 8 bits and 53 bytes. With those values a full cell is reached, including the end-of-cell wrap, along with a paused-and-resumed cell, a FIFO stall and a realigning start tag. Each of these is traced byte by byte against a FIFO model whose byte values use all eight bits.

// File: rtl/urx_pkg.sv
package urx_pkg;
  typedef enum logic {
    SEL_IDLE = 1'b0,
    SEL_XFER = 1'b1
  } sel_state_e;
endpackage

// File: rtl/urx_poll.sv
module urx_poll #(
  parameter int ADDR_W = 5,
  parameter logic [ADDR_W-1:0] PORT_ADDR = ADDR_W'(3),
  parameter logic [ADDR_W-1:0] NULL_ADDR = {ADDR_W{1'b1}}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              cell_ready,
  input  logic              mid_cell,
  output logic              clav,
  output logic              clav_oe
);
  logic hit;
  assign hit = (addr == PORT_ADDR) && (addr != NULL_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clav    <= 1'b0;
      clav_oe <= 1'b0;
    end else begin
      clav_oe <= hit;
      clav    <= hit && (cell_ready || mid_cell);
    end
  end

  assert_null_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == NULL_ADDR) |=> !clav_oe);
endmodule

// File: rtl/urx_select.sv
module urx_select
  import urx_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter logic [ADDR_W-1:0] PORT_ADDR = ADDR_W'(3)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              enb_n,
  input  logic              cell_end,
  output logic              active
);
  logic              enb_q;
  logic [ADDR_W-1:0] addr_q;
  sel_state_e        state;
  logic              start;

  assign start  = !enb_n && enb_q && (addr_q == PORT_ADDR);
  assign active = !enb_n && (start || (state == SEL_XFER));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enb_q  <= 1'b1;
      addr_q <= {ADDR_W{1'b1}};
      state  <= SEL_IDLE;
    end else begin
      enb_q  <= enb_n;
      addr_q <= addr;
      state  <= (active && !cell_end) ? SEL_XFER : SEL_IDLE;
    end
  end

  assert_release_after_cell_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cell_end |=> !active);
endmodule

// File: rtl/urx_stream.sv
module urx_stream #(
  parameter int DATA_W = 8,
  parameter int CELL_BYTES = 53
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              fifo_valid,
  input  logic [DATA_W-1:0] fifo_data,
  input  logic              fifo_sop,
  output logic              fifo_ready,
  output logic              cell_end,
  output logic              mid_cell,
  output logic [DATA_W-1:0] data_q,
  output logic              soc_q,
  output logic              oe_q
);
  localparam int POS_W = $clog2(CELL_BYTES);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(CELL_BYTES - 1);

  logic [POS_W-1:0] cnt;
  logic [POS_W-1:0] pos;
  logic             take;

  assign fifo_ready = active;
  assign take       = active && fifo_valid;
  assign pos        = fifo_sop ? '0 : cnt;
  assign cell_end   = take && (pos == LAST_POS);
  assign mid_cell   = (cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      data_q <= '0;
      soc_q  <= 1'b0;
      oe_q   <= 1'b0;
    end else begin
      oe_q  <= active;
      soc_q <= take && (pos == '0);
      if (take) begin
        data_q <= fifo_data;
        cnt    <= cell_end ? '0 : pos + POS_W'(1);
      end
    end
  end

  assert_soc_driven_R2: assert property (@(posedge clk) disable iff (!rst_n)
    soc_q |-> oe_q);
  assert_hold_on_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(data_q));
  assert_realign_soc_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (take && fifo_sop) |=> soc_q);
endmodule

// File: rtl/utopia_rx_port.sv
module utopia_rx_port #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 5,
  parameter int CELL_BYTES = 53,
  parameter logic [ADDR_W-1:0] PORT_ADDR = ADDR_W'(3)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] rx_addr,
  input  logic              rx_enb_n,
  input  logic              cell_ready,
  input  logic              fifo_valid,
  input  logic [DATA_W-1:0] fifo_data,
  input  logic              fifo_sop,
  output logic              fifo_ready,
  output logic              rx_clav,
  output logic              rx_clav_oe,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_soc,
  output logic              rx_data_oe
);
  localparam logic [ADDR_W-1:0] NULL_ADDR = {ADDR_W{1'b1}};

  logic active;
  logic cell_end;
  logic mid_cell;

  urx_select #(.ADDR_W(ADDR_W), .PORT_ADDR(PORT_ADDR)) u_select (
    .clk(clk), .rst_n(rst_n), .addr(rx_addr), .enb_n(rx_enb_n),
    .cell_end(cell_end), .active(active)
  );

  urx_stream #(.DATA_W(DATA_W), .CELL_BYTES(CELL_BYTES)) u_stream (
    .clk(clk), .rst_n(rst_n), .active(active), .fifo_valid(fifo_valid),
    .fifo_data(fifo_data), .fifo_sop(fifo_sop), .fifo_ready(fifo_ready),
    .cell_end(cell_end), .mid_cell(mid_cell), .data_q(rx_data),
    .soc_q(rx_soc), .oe_q(rx_data_oe)
  );

  urx_poll #(.ADDR_W(ADDR_W), .PORT_ADDR(PORT_ADDR), .NULL_ADDR(NULL_ADDR)) u_poll (
    .clk(clk), .rst_n(rst_n), .addr(rx_addr), .cell_ready(cell_ready),
    .mid_cell(mid_cell), .clav(rx_clav), .clav_oe(rx_clav_oe)
  );

  assert_release_on_enb_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_data_oe |-> $past(!rx_enb_n));
  assert_clav_mid_cell_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mid_cell) && rx_clav_oe) |-> rx_clav);
endmodule

// File: tb/tb_utopia_rx_port.sv
module tb_utopia_rx_port;
  localparam int CELL = 53;
  localparam logic [4:0] MY  = 5'd30;
  localparam logic [4:0] NUL = 5'h1F;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [4:0] rx_addr = NUL;
  logic       rx_enb_n = 1'b1;
  logic       cell_ready = 1'b0;
  logic       fifo_valid = 1'b1;
  logic [7:0] fifo_data;
  logic       fifo_sop;
  logic       fifo_ready, rx_clav, rx_clav_oe, rx_soc, rx_data_oe;
  logic [7:0] rx_data;

  int rd = 0;
  int base = 0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  function automatic logic [7:0] bval(int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  assign fifo_data = bval(rd);
  assign fifo_sop  = (((rd - base) % CELL) == 0);

  utopia_rx_port #(.PORT_ADDR(MY)) dut (
    .clk(clk), .rst_n(rst_n), .rx_addr(rx_addr), .rx_enb_n(rx_enb_n),
    .cell_ready(cell_ready), .fifo_valid(fifo_valid), .fifo_data(fifo_data),
    .fifo_sop(fifo_sop), .fifo_ready(fifo_ready), .rx_clav(rx_clav),
    .rx_clav_oe(rx_clav_oe), .rx_data(rx_data), .rx_soc(rx_soc),
    .rx_data_oe(rx_data_oe)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(logic enb, logic [4:0] a);
    bit took;
    @(negedge clk);
    rx_enb_n = enb;
    rx_addr  = a;
    #1;
    took = fifo_ready && fifo_valid;
    @(posedge clk);
    #1;
    if (took) rd++;
  endtask

  task automatic t_reset();
    chk("R4 reset data_oe", rx_data_oe, 0);
    chk("R6 reset clav_oe", rx_clav_oe, 0);
    chk("R2 reset soc", rx_soc, 0);
    chk("R3 reset fifo_ready", fifo_ready, 0);
  endtask

  task automatic t_poll();
    cell_ready = 1'b1;
    cyc(1'b1, MY);
    chk("R5 clav_oe on own addr", rx_clav_oe, 1);
    chk("R5 clav ready", rx_clav, 1);
    cell_ready = 1'b0;
    cyc(1'b1, MY);
    chk("R5 clav not ready", rx_clav, 0);
    chk("R5 clav_oe", rx_clav_oe, 1);
    cyc(1'b1, NUL);
    chk("R6 null addr", rx_clav_oe, 0);
    cyc(1'b1, 5'd7);
    chk("R6 other addr", rx_clav_oe, 0);
    cell_ready = 1'b1;
  endtask

  task automatic t_full_cell();
    int start = rd;
    cyc(1'b1, MY);
    for (int k = 0; k < CELL; k++) begin
      cell_ready = (k == 10) ? 1'b0 : 1'b1;
      cyc(1'b0, (k == 10) ? MY : NUL);
      chk("R1 byte value", rx_data, bval(start + k));
      chk("R2 soc position", rx_soc, (k == 0) ? 1 : 0);
      chk("R4 data_oe during cell", rx_data_oe, 1);
      if (k == 10) begin
        chk("R7 clav_oe mid cell", rx_clav_oe, 1);
        chk("R7 clav held mid cell", rx_clav, 1);
      end
    end
    cell_ready = 1'b1;
    cyc(1'b0, NUL);
    chk("R9 released after last byte", rx_data_oe, 0);
    chk("R9 bytes consumed", rd, start + CELL);
  endtask

  task automatic t_wrong_select();
    int r0 = rd;
    cyc(1'b1, 5'd4);
    cyc(1'b0, NUL);
    chk("R8 wrong addr no select", rx_data_oe, 0);
    cyc(1'b0, MY);
    cyc(1'b0, NUL);
    chk("R8 addr while enb low no select", rx_data_oe, 0);
    chk("R8 nothing consumed", rd, r0);
    cyc(1'b1, NUL);
  endtask

  task automatic t_pause_stall();
    int start = rd;
    cyc(1'b1, MY);
    for (int k = 0; k < 20; k++) begin
      cyc(1'b0, NUL);
      chk("R1 byte before pause", rx_data, bval(start + k));
    end
    cyc(1'b1, NUL);
    chk("R4 released on enb high", rx_data_oe, 0);
    cyc(1'b1, NUL);
    chk("R10 position kept while paused", rd, start + 20);
    cyc(1'b1, MY);
    cyc(1'b0, NUL);
    chk("R10 resume byte", rx_data, bval(start + 20));
    chk("R10 no soc on resume", rx_soc, 0);
    fifo_valid = 1'b0;
    cyc(1'b0, NUL);
    chk("R3 data held on stall", rx_data, bval(start + 20));
    chk("R3 nothing consumed on stall", rd, start + 21);
    chk("R3 still driving", rx_data_oe, 1);
    fifo_valid = 1'b1;
    for (int k = 21; k < CELL; k++) begin
      cyc(1'b0, NUL);
      chk("R1 byte after resume", rx_data, bval(start + k));
    end
    cyc(1'b0, NUL);
    chk("R9 end after resumed cell", rx_data_oe, 0);
    chk("R9 resumed cell length", rd, start + CELL);
    cyc(1'b1, NUL);
  endtask

  task automatic t_realign();
    int start = rd;
    int seen = 0;
    cyc(1'b1, MY);
    for (int k = 0; k < 5; k++) cyc(1'b0, NUL);
    base = rd;
    cyc(1'b0, NUL);
    chk("R11 soc on tagged byte", rx_soc, 1);
    chk("R11 tagged byte value", rx_data, bval(start + 5));
    seen = 1;
    for (int k = 1; k < CELL; k++) begin
      cyc(1'b0, NUL);
      if (rx_data_oe && !rx_soc) seen++;
    end
    chk("R11 bytes after realign", seen, CELL);
    cyc(1'b0, NUL);
    chk("R11 cell ends 53 after tag", rx_data_oe, 0);
    cyc(1'b1, NUL);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    t_reset();
    t_poll();
    t_full_cell();
    t_wrong_select();
    t_pause_stall();
    t_realign();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule